// File: doc/BRIEF.md
# Quadrature Encoder Edge Decoder

This block takes the two phase signals and the index signal of an incremental encoder and brings them into the system clock domain. From the synchronized phases it works out which way the shaft is turning and emits single-cycle count strobes. A downstream position counter consumes these strobes. The resolution is chosen by a 3-bit mode field. In the four-edge mode every transition of either phase counts. In the two-edge mode only transitions of phase A count, but phase B still sets the direction. The remaining mode codes stop all counting.

The current direction is always available as a status output. It is copied onto a pin output only when a pin-enable input is set. An index strobe is produced on a rising index edge, but only when both phases are low in the same sample. The block has no position register, no reset policy and no error logic. Each input passes through a plain flop synchronizer and is not filtered.

Top module: `quad_edge_decoder`

## Requirements
- R1: While `rstN` is low, and directly after it is released, `countPulse`, `idxPulse`, `dirFlag` and `dirPin` are all 0.
- R2: With `modeSel` equal to 3'b110 or 3'b111 (four-edge), every single-bit change of the phase pair gives exactly one `countPulse`, lasting one cycle.
- R3: Take the phase state as {B,A}. A step along 00→01→11→10→00 (A leading B) sets `dirFlag` to 1. A step along the reverse order sets it to 0. The new value appears in the same cycle as the count pulse for that step.
- R4: With `modeSel` equal to 3'b100 or 3'b101 (two-edge), every rising or falling edge of phase A gives one `countPulse`. Edges of phase B alone give none.
- R5: In two-edge mode, and in every other mode, every single-bit step updates `dirFlag` by the rule of R3. This includes steps of phase B alone.
- R6: With `modeSel[2]` equal to 0 (codes 3'b000 to 3'b011), no `countPulse` is ever emitted.
- R7: If A and B both change between two synchronized samples, no count pulse is emitted and `dirFlag` keeps its value. A sample equal to the previous one is also ignored in the same way.
- R8: `idxPulse` is high for one cycle when the synchronized index rises while the synchronized A and B are both 0. An index rise in any other phase state gives no pulse.
- R9: `dirPin` equals `dirFlag` when `dirOutEn` is 1. Otherwise it is 0. `dirFlag` is valid regardless of `dirOutEn`.
- R10: With the default two synchronizer stages, a count or index pulse caused by an input change shows up on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| indexIn | input | 1 | Encoder index, asynchronous |
| modeSel | input | 3 | Resolution mode: 11x four-edge, 10x two-edge, 0xx off |
| dirOutEn | input | 1 | Enables direction onto `dirPin` |
| countPulse | output | 1 | One-cycle count strobe |
| dirFlag | output | 1 | Direction status, 1 = forward |
| dirPin | output | 1 | Gated direction for an external pin |
| idxPulse | output | 1 | One-cycle qualified index strobe |

## Verification
The hardest case to reach is the illegal step, where A and B move in the same sample. An encoder that obeys the rules never produces it. The bench creates it by driving both phases in the same cycle, from every start state and in every mode. It then checks that `dirFlag` keeps the direction left by the previous legal step. It covers all sixteen from/to phase pairs, eight mode codes and both pin-enable settings. Each index rise is placed in one of the four held phase states.

// File: rtl/enc_pkg.sv
package enc_pkg;

  typedef enum logic [1:0] {
    RES_OFF = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2
  } res_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntStep;
    logic dirLoad;
    logic dirUp;
    logic idxHit;
  } step_ctl_t;

  function automatic res_mode_e decodeMode(input logic [2:0] code);
    if (code[2] && code[1])  return RES_X4;
    if (code[2] && !code[1]) return RES_X2;
    return RES_OFF;
  endfunction

  // {B,A}: 00 -> 01 -> 11 -> 10 -> 00 is forward
  function automatic logic isForward(input logic [1:0] prevBA, input logic [1:0] curBA);
    case ({prevBA, curBA})
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/enc_datapath.sv
module enc_datapath
  import enc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      phaseA,
  input  logic      phaseB,
  input  logic      indexIn,
  input  step_ctl_t ctl,
  output logic [1:0] curBA,
  output logic [1:0] prevBA,
  output logic       curIdx,
  output logic       prevIdx,
  output logic       countPulse,
  output logic       dirFlag,
  output logic       idxPulse
);

  localparam int SIG_W = 3;

  logic [SIG_W-1:0] chain [SYNC_STAGES];
  logic [SIG_W-1:0] prevSample;
  logic [SIG_W-1:0] rawIn;

  assign rawIn = {indexIn, phaseB, phaseA};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= rawIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSample <= '0;
    else       prevSample <= chain[SYNC_STAGES-1];
  end

  assign curBA   = chain[SYNC_STAGES-1][1:0];
  assign curIdx  = chain[SYNC_STAGES-1][2];
  assign prevBA  = prevSample[1:0];
  assign prevIdx = prevSample[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countPulse <= 1'b0;
      dirFlag    <= 1'b0;
      idxPulse   <= 1'b0;
    end else begin
      countPulse <= ctl.cntStep;
      idxPulse   <= ctl.idxHit;
      if (ctl.dirLoad) dirFlag <= ctl.dirUp;
    end
  end

  // R7: a count needs a one-bit change in the sampled pair
  p_pulse_needs_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> $countones($past(curBA) ^ $past(prevBA)) == 1);

  // R7: without a legal step the direction holds
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.dirLoad) |-> $stable(dirFlag));

  // R8: index pulse only with both phases low
  p_idx_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    idxPulse |-> $past(curBA) == 2'b00);

endmodule

// File: rtl/enc_control.sv
module enc_control
  import enc_pkg::*;
(
  input  logic [2:0] modeSel,
  input  logic [1:0] curBA,
  input  logic [1:0] prevBA,
  input  logic       curIdx,
  input  logic       prevIdx,
  output step_ctl_t  ctl
);

  res_mode_e resMode;
  logic [1:0] delta;
  logic       oneStep;

  assign resMode = decodeMode(modeSel);
  assign delta   = curBA ^ prevBA;
  assign oneStep = (delta == 2'b01) || (delta == 2'b10);

  always_comb begin
    ctl = '0;
    ctl.dirLoad = oneStep;
    ctl.dirUp   = isForward(prevBA, curBA);
    unique case (resMode)
      RES_X4:  ctl.cntStep = oneStep;
      RES_X2:  ctl.cntStep = oneStep && delta[0];
      default: ctl.cntStep = 1'b0;
    endcase
    ctl.idxHit = curIdx && !prevIdx && (curBA == 2'b00);
  end

  // R4: in two-edge mode a count step always comes from phase A
  always_comb begin
    if (resMode == RES_X2 && ctl.cntStep)
      a_x2_a_only_r4: assert (delta == 2'b01);
  end

endmodule

// File: rtl/quad_edge_decoder.sv
module quad_edge_decoder
  import enc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseA,
  input  logic       phaseB,
  input  logic       indexIn,
  input  logic [2:0] modeSel,
  input  logic       dirOutEn,
  output logic       countPulse,
  output logic       dirFlag,
  output logic       dirPin,
  output logic       idxPulse
);

  step_ctl_t  ctl;
  logic [1:0] curBA, prevBA;
  logic       curIdx, prevIdx;

  enc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .phaseA(phaseA), .phaseB(phaseB), .indexIn(indexIn),
    .ctl(ctl),
    .curBA(curBA), .prevBA(prevBA), .curIdx(curIdx), .prevIdx(prevIdx),
    .countPulse(countPulse), .dirFlag(dirFlag), .idxPulse(idxPulse)
  );

  enc_control u_ctl (
    .modeSel(modeSel),
    .curBA(curBA), .prevBA(prevBA), .curIdx(curIdx), .prevIdx(prevIdx),
    .ctl(ctl)
  );

  assign dirPin = dirOutEn & dirFlag;

  // R6: counting off for codes 0xx
  p_off_no_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel[2] |=> !countPulse);

endmodule

// File: tb/quad_edge_decoder_test.sv
`timescale 1ns/1ps
module quad_edge_decoder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseA = 1'b0, phaseB = 1'b0, indexIn = 1'b0;
  logic [2:0] modeSel = 3'b110;
  logic dirOutEn = 1'b0;
  logic countPulse, dirFlag, dirPin, idxPulse;

  int vecs = 0;
  int errs = 0;
  logic expDir = 1'b0;
  logic [1:0] curState = 2'b00;
  bit done = 0;

  always #2 clk = ~clk;

  quad_edge_decoder uut (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB), .indexIn(indexIn),
    .modeSel(modeSel), .dirOutEn(dirOutEn),
    .countPulse(countPulse), .dirFlag(dirFlag), .dirPin(dirPin), .idxPulse(idxPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic fwdStep(input logic [1:0] p, input logic [1:0] n);
    return (p == 2'b00 && n == 2'b01) || (p == 2'b01 && n == 2'b11) ||
           (p == 2'b11 && n == 2'b10) || (p == 2'b10 && n == 2'b00);
  endfunction

  // drive a {B,A} state, watch five cycles
  task automatic applyState(input logic [1:0] nxt);
    logic [1:0] d;
    bit single;
    int expPulses, pulses, firstCyc;
    d = nxt ^ curState;
    single = (d == 2'b01) || (d == 2'b10);
    if (!single)                        expPulses = 0;
    else if (modeSel[2] && modeSel[1])  expPulses = 1;
    else if (modeSel[2])                expPulses = d[0] ? 1 : 0;
    else                                expPulses = 0;
    if (single) expDir = fwdStep(curState, nxt);
    @(negedge clk);
    phaseA = nxt[0];
    phaseB = nxt[1];
    pulses = 0;
    firstCyc = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (countPulse) begin
        pulses++;
        if (firstCyc == 0) firstCyc = k;
      end
    end
    curState = nxt;
    if (!single)
      check("R7 pulses on illegal/no step", pulses, 0);
    else if (!modeSel[2])
      check("R6 pulses with counting off", pulses, 0);
    else if (!modeSel[1])
      check("R4 two-edge pulse count", pulses, expPulses);
    else
      check("R2 four-edge pulse count", pulses, expPulses);
    if (expPulses == 1) check("R10 count latency", firstCyc, 3);
    if (!single)            check("R7 direction held", dirFlag, expDir);
    else if (modeSel[2:1] == 2'b11) check("R3 direction", dirFlag, expDir);
    else                    check("R5 direction tracking", dirFlag, expDir);
    check("R9 direction pin", dirPin, dirOutEn ? expDir : 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 countPulse in reset", countPulse, 0);
    check("R1 dirFlag in reset", dirFlag, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idxPulse after reset", idxPulse, 0);
    check("R1 dirPin after reset", dirPin, 0);

    for (int m = 0; m < 8; m++) begin
      for (int en = 0; en < 2; en++) begin
        modeSel = 3'(m);
        dirOutEn = en[0];
        for (int f = 0; f < 4; f++)
          for (int t = 0; t < 4; t++) begin
            applyState(2'(f));
            applyState(2'(t));
          end
      end
    end

    // R8 index qualification in each phase state
    modeSel = 3'b110;
    for (int s = 0; s < 4; s++) begin
      int ip, ic;
      applyState(2'(s ^ (s >> 1)));
      @(negedge clk);
      indexIn = 1'b1;
      ip = 0; ic = 0;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        if (idxPulse) begin ip++; if (ic == 0) ic = k; end
      end
      check("R8 index pulse count", ip, (curState == 2'b00) ? 1 : 0);
      if (curState == 2'b00) check("R10 index latency", ic, 3);
      @(negedge clk);
      indexIn = 1'b0;
      ip = 0;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        if (idxPulse) ip++;
      end
      check("R8 no pulse on index fall", ip, 0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule